// File: doc/BRIEF.md
# Clear-on-Read Statistics Counter Bank

This block holds the event counters for one switch port. Each counter has its own single-cycle event strobe, driven by the receive and transmit classification logic, and advances by one on every cycle in which that strobe is high. A host reads the counters through a small word-wide register port. The counters are packed as consecutive 32-bit words inside a fixed address window, and each read returns its data one cycle after the request.

A global mode input sets what a read does to the counter. With the input low, which is the default software keeps, a read returns the value and also zeroes the counter in the same access. With the input high, a read only observes the value. If an event and a clearing read reach the same counter in one cycle, the event is not lost. Counter contents are undefined after reset. Software brings them to zero by reading each counter once with the mode input low.

The host port takes single-word transactions only. A request marked as a burst is answered with an error pulse and is not serviced.

Top module: `stat_bank`

## Requirements
- R1: Each counter is CTR_W bits wide (default 32). It increments by one in every cycle in which its strobe `evt_i[k]` is high, and it wraps from all-ones to zero without saturating.
- R2: Counter k sits at byte offset 4*k. The word index is `addr_i[ADDR_W-1:2]`, and address bits 1:0 are ignored.
- R3: A single-word request (`req_i`=1, `burst_i`=0) raises `rvalid_o` in the following cycle. `rdata_o` then holds the addressed counter's value from before that cycle's increment, zero-extended to BUS_W. Without a request, `rvalid_o` stays low.
- R4: With `clr_mode_i`=0, a read leaves the addressed counter at 0 afterwards.
- R5: With `clr_mode_i`=1, a read leaves the counter unchanged, and events on that cycle are still counted.
- R6: If a clearing read and the counter's event strobe fall in the same cycle, the read returns the pre-increment value and the counter becomes 1.
- R7: A read of a word index at or above NUM_CTR inside the window returns 0 with `rvalid_o`=1 and changes no counter.
- R8: A request with `burst_i`=1 produces `err_o`=1 in the next cycle with `rvalid_o`=0, and changes no counter.
- R9: After reset, `rvalid_o`, `err_o` and `rdata_o` are 0. Counter contents are undefined until each counter has been read once with `clr_mode_i`=0.
- R10: Events on counters that are not being read are counted in every cycle, independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the host response path |
| clr_mode_i | input | 1 | 0: reads clear the counter; 1: reads leave the counter unchanged |
| evt_i | input | NUM_CTR | One event strobe per counter |
| req_i | input | 1 | Host read request, one cycle |
| burst_i | input | 1 | Marks the request as a burst; the request is rejected |
| addr_i | input | ADDR_W | Byte offset within the counter window |
| rdata_o | output | BUS_W | Read data, valid with rvalid_o, 0 otherwise |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |
| err_o | output | 1 | Burst rejected, one cycle after the request |

## Verification
The hardest case to reach from the ports is a wrap from all-ones to zero, because at full width it would take billions of events. The bench therefore builds the block with an 8-bit counter width, which keeps every increment path and makes the wrap reachable in 256 strobes. The same-cycle collision between a clearing read and an event depends on the exact cycle alignment. The bench drives the strobe and the read on the same falling edge, and a second read then shows whether the surviving count is 1.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned BYTE_SEL_W = 2;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_HOLE  = 2'd2,
      ACC_BURST = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/stat_bank_dec.sv
module stat_bank_dec
   import stat_bank_pkg::*;
#(
   parameter int unsigned NUM_CTR = 8,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               req_i,
   input  logic               burst_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output acc_kind_e          kind_o,
   output logic [NUM_CTR-1:0] sel_o
);
   localparam int unsigned IDX_W = ADDR_W - BYTE_SEL_W;

   logic [IDX_W-1:0] word_idx;
   logic             in_map;

   assign word_idx = addr_i[ADDR_W-1:BYTE_SEL_W];
   assign in_map   = (32'(word_idx) < NUM_CTR);

   always_comb begin
      kind_o = ACC_NONE;
      if (req_i) begin
         if (burst_i)     kind_o = ACC_BURST;
         else if (in_map) kind_o = ACC_READ;
         else             kind_o = ACC_HOLE;
      end
   end

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_sel
      assign sel_o[k] = (kind_o == ACC_READ) && (32'(word_idx) == k);
   end

   always_comb begin
      if (kind_o == ACC_READ)
         a_sel_onehot_r2: assert ($onehot0(sel_o) && (sel_o != '0));
      else
         a_sel_idle_r7: assert (sel_o == '0);
   end
endmodule

// File: rtl/stat_bank_cell.sv
module stat_bank_cell #(
   parameter int unsigned CTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             rd_sel_i,
   input  logic             clr_en_i,
   output logic [CTR_W-1:0] cnt_o
);
   logic [CTR_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rd_sel_i && clr_en_i)
         cnt_q <= CTR_W'(evt_i);
      else if (evt_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_i && clr_en_i && !evt_i) |=> (cnt_q == '0));

   p_clear_keeps_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_i && clr_en_i && evt_i) |=> (cnt_q == CTR_W'(1)));
endmodule

// File: rtl/stat_bank_mux.sv
module stat_bank_mux #(
   parameter int unsigned NUM_CTR = 8,
   parameter int unsigned CTR_W   = 32,
   parameter int unsigned BUS_W   = 32
) (
   input  logic [NUM_CTR*CTR_W-1:0] cnt_flat_i,
   input  logic [NUM_CTR-1:0]       sel_i,
   output logic [BUS_W-1:0]         word_o
);
   logic [NUM_CTR-1:0][CTR_W-1:0] masked;
   logic [CTR_W-1:0]              merged;

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_mask
      assign masked[k] = cnt_flat_i[k*CTR_W +: CTR_W] & {CTR_W{sel_i[k]}};
   end

   always_comb begin
      merged = '0;
      for (int k = 0; k < NUM_CTR; k++) merged = merged | masked[k];
   end

   if (CTR_W == BUS_W) begin : g_direct
      assign word_o = merged;
   end else begin : g_pad
      assign word_o = {{(BUS_W-CTR_W){1'b0}}, merged};
   end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
   import stat_bank_pkg::*;
#(
   parameter int unsigned NUM_CTR = 8,
   parameter int unsigned CTR_W   = 32,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_mode_i,
   input  logic [NUM_CTR-1:0] evt_i,
   input  logic               req_i,
   input  logic               burst_i,
   input  logic [ADDR_W-1:0]  addr_i,
   output logic [BUS_W-1:0]   rdata_o,
   output logic               rvalid_o,
   output logic               err_o
);
   localparam int unsigned IDX_W = ADDR_W - BYTE_SEL_W;

   if (ADDR_W <= BYTE_SEL_W) begin : g_bad_addr
      $error("stat_bank: ADDR_W must exceed the byte-select width");
   end
   if (NUM_CTR < 1 || NUM_CTR > (1 << IDX_W)) begin : g_bad_num
      $error("stat_bank: NUM_CTR does not fit the address window");
   end
   if (CTR_W < 1 || CTR_W > BUS_W) begin : g_bad_width
      $error("stat_bank: CTR_W must be between 1 and BUS_W");
   end

   acc_kind_e                kind;
   logic [NUM_CTR-1:0]       sel;
   logic [NUM_CTR*CTR_W-1:0] cnt_flat;
   logic [BUS_W-1:0]         mux_word;
   logic                     clr_en;

   assign clr_en = ~clr_mode_i;

   stat_bank_dec #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_dec (
      .req_i   (req_i),
      .burst_i (burst_i),
      .addr_i  (addr_i),
      .kind_o  (kind),
      .sel_o   (sel)
   );

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
      stat_bank_cell #(.CTR_W(CTR_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt_i[k]),
         .rd_sel_i (sel[k]),
         .clr_en_i (clr_en),
         .cnt_o    (cnt_flat[k*CTR_W +: CTR_W])
      );
   end

   stat_bank_mux #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .BUS_W(BUS_W)) u_mux (
      .cnt_flat_i (cnt_flat),
      .sel_i      (sel),
      .word_o     (mux_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid_o <= 1'b0;
         err_o    <= 1'b0;
         rdata_o  <= '0;
      end else begin
         rvalid_o <= (kind == ACC_READ) || (kind == ACC_HOLE);
         err_o    <= (kind == ACC_BURST);
         rdata_o  <= (kind == ACC_READ) ? mux_word : '0;
      end
   end

   p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !burst_i) |=> (rvalid_o && !err_o));

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!rvalid_o && !err_o));

   p_burst_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && burst_i) |=> (err_o && !rvalid_o && rdata_o == '0));

   p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_HOLE) |=> (rvalid_o && rdata_o == '0));
endmodule

// File: tb/sim_stat_bank.sv
module sim_stat_bank;
   localparam int NC = 8;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr_mode_i = 1'b0;
   logic [NC-1:0] evt_i = '0;
   logic          req_i = 1'b0;
   logic          burst_i = 1'b0;
   logic [7:0]    addr_i = '0;
   logic [31:0]   rdata_o;
   logic          rvalid_o;
   logic          err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [CW-1:0] model [NC];
   bit            known [NC];

   always #5 clk = ~clk;

   stat_bank #(.NUM_CTR(NC), .CTR_W(CW), .BUS_W(32), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .clr_mode_i(clr_mode_i), .evt_i(evt_i),
      .req_i(req_i), .burst_i(burst_i), .addr_i(addr_i),
      .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One host cycle: drive on falling edge, check on the following falling edge.
   task automatic cyc(input logic rq, input logic bu, input logic [7:0] ad,
                      input logic [NC-1:0] ev, input logic cm, input string tag);
      int idx;
      bit mapped;
      bit chk_d;
      logic [31:0] exp_d;
      idx    = int'(ad[7:2]);
      mapped = (idx < NC);
      chk_d  = rq && !bu && (!mapped || known[idx]);
      exp_d  = (rq && !bu && mapped) ? 32'(model[idx]) : 32'h0;
      for (int k = 0; k < NC; k++) begin
         if (rq && !bu && mapped && idx == k && !cm) begin
            model[k] = CW'(ev[k]);
            known[k] = 1;
         end else begin
            model[k] = model[k] + CW'(ev[k]);
         end
      end
      req_i = rq; burst_i = bu; addr_i = ad; evt_i = ev; clr_mode_i = cm;
      @(posedge clk);
      @(negedge clk);
      req_i = 0; burst_i = 0; evt_i = '0;
      chk({tag, " rvalid"}, 32'(rvalid_o), 32'(rq && !bu));
      chk({tag, " err"}, 32'(err_o), 32'(rq && bu));
      if (chk_d) chk({tag, " rdata"}, rdata_o, exp_d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int k = 0; k < NC; k++) begin model[k] = '0; known[k] = 0; end
      repeat (3) @(negedge clk);
      // R9: reset values of the response path
      chk("R9 rvalid at reset", 32'(rvalid_o), 0);
      chk("R9 err at reset", 32'(err_o), 0);
      chk("R9 rdata at reset", rdata_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9/R4: initialise by reading every counter in clear mode, then confirm zero
      for (int k = 0; k < NC; k++) cyc(1, 0, 8'(4*k), '0, 0, "R9 init");
      for (int k = 0; k < NC; k++) cyc(1, 0, 8'(4*k), '0, 1, "R4 zero after init");

      // R1/R2/R5/R4: per-counter sweep of event counts, low byte bits varied
      for (int k = 0; k < NC; k++) begin
         for (int n = 0; n < 6; n++) begin
            for (int e = 0; e < n; e++) cyc(0, 0, 0, NC'(1 << k), 1, "R1");
            cyc(1, 0, 8'(4*k + (n % 4)), '0, 1, "R2 R5 keep read");
            cyc(1, 0, 8'(4*k), '0, 1, "R5 second read");
            cyc(1, 0, 8'(4*k), '0, 0, "R4 clearing read");
            cyc(1, 0, 8'(4*k), '0, 1, "R4 after clear");
         end
      end

      // R10: independent counting across counters with a mixed pattern
      for (int i = 0; i < 20; i++) cyc(0, 0, 0, NC'(8'hA5 ^ i), 1, "R10");
      for (int k = 0; k < NC; k++) cyc(1, 0, 8'(4*k), NC'(8'h3C), 1, "R10 read");
      for (int k = 0; k < NC; k++) cyc(1, 0, 8'(4*k), '0, 1, "R10 reread");

      // R6: clearing read collides with an event on the same counter
      for (int k = 0; k < NC; k++) begin
         cyc(0, 0, 0, NC'(1 << k), 1, "R6 prime");
         cyc(1, 0, 8'(4*k), NC'(1 << k), 0, "R6 collide");
         cyc(1, 0, 8'(4*k), '0, 1, "R6 kept event");
      end

      // R5: keep-mode read collides with an event
      cyc(1, 0, 8'd12, NC'(8'h08), 1, "R5 collide");
      cyc(1, 0, 8'd12, '0, 1, "R5 counted");

      // R7: every unmapped word inside the window, clear mode, with events running
      for (int w = NC; w < 64; w++) cyc(1, 0, 8'(4*w + (w % 4)), NC'(w), 0, "R7 hole");
      for (int k = 0; k < NC; k++) cyc(1, 0, 8'(4*k), '0, 1, "R7 untouched");

      // R8: bursts to each mapped counter are rejected and clear nothing
      for (int k = 0; k < NC; k++) cyc(1, 1, 8'(4*k), '0, 0, "R8 burst");
      for (int k = 0; k < NC; k++) cyc(1, 0, 8'(4*k), '0, 1, "R8 untouched");

      // R1: wrap from all-ones to zero
      cyc(1, 0, 8'd8, '0, 0, "R1 clear");
      for (int i = 0; i < 255; i++) cyc(0, 0, 0, NC'(8'h04), 1, "R1 fill");
      cyc(1, 0, 8'd8, '0, 1, "R1 at max");
      cyc(0, 0, 0, NC'(8'h04), 1, "R1 wrap event");
      cyc(1, 0, 8'd8, '0, 1, "R1 wrapped");

      // R3/R10: pseudo-random mix of reads, modes and events
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], {lfsr[12:7], lfsr[6:5]} & 8'h3F,
             NC'(lfsr[15:8]), lfsr[9], "R3 mix");
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule